// File: doc/BRIEF.md
# Two-Wire Register Slave with Auto-Advancing Pointer

This block is a two-wire (I2C) slave that gives a bus master access to a small internal bank of 8-bit registers. Both bus lines are sampled in the system clock domain through synchronizers. The slave recognises start and stop conditions from edges of the data line while the clock line is high. It answers one 7-bit device address whose lowest bit comes from a strap pin. SDA is driven open-drain: the block only produces an enable that pulls the line low.

A write transaction sets an 8-bit register pointer from its first byte after the address and stores every later byte. A read transaction returns bytes starting at the pointer as it stands. The pointer is kept between transactions and advances by one after every data byte in either direction, wrapping from 0xFF to 0x00. To read a chosen register, a master writes the pointer alone and then issues a repeated start with the read address. A separate test port writes and reads the register bank directly.

Top module: `i2c_regslave`

## Requirements
- R1: After reset the SDA pull-down enable is 0 and every register reads 0x00 through the test port.
- R2: With the strap at 0 the slave acknowledges address bytes 0x40 (write) and 0x41 (read); with the strap at 1 it acknowledges 0x42 and 0x43. Acknowledge means the pull-down enable is 1 while SCL is high in the ninth clock of the byte.
- R3: An address byte that does not match is not acknowledged, and the pull-down enable stays 0 until the next start; bytes sent in the meantime change no register.
- R4: In a write transaction the first byte after the address loads the pointer and each following byte is stored at the pointer. The slave acknowledges every one of these bytes.
- R5: The pointer advances by one after every data byte, written or read, and wraps from 0xFF to 0x00.
- R6: Read data leaves the slave most significant bit first, with the pull-down enable (1 = bit 0) changing only while SCL is low. The enable is 0 in the acknowledge slot of each read byte.
- R7: A not-acknowledge (SDA high in the ninth clock) after a read byte ends the slave's output: the enable stays 0 until the next start.
- R8: A pointer write followed by a repeated start with the read address returns the register at the written pointer, then the next ones.
- R9: A start or stop arriving in the middle of a byte abandons that byte. No register is written by it, and after a start the next byte is treated as an address.
- R10: The test port writes the register at its address when its write strobe is 1 and shows that register's content combinationally.
- R11: The pointer persists across a stop: a later read with no pointer write continues where the last transaction left off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL line level, asynchronous |
| sda_in | input | 1 | SDA line level, asynchronous |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_sel | input | 1 | Strap for the lowest device address bit |
| tst_we | input | 1 | Test port write strobe |
| tst_addr | input | 8 | Test port register address |
| tst_wdata | input | 8 | Test port write data |
| tst_rdata | output | 8 | Register content at tst_addr |

## Verification
The assertions take for granted that the bus is well formed. SCL levels last many system clocks, so every edge survives the synchronizer. SDA is never moved by the master at the same time as SCL. The master also does not try to raise a start or stop while the slave holds SDA low. The bench drives both lines as an open-drain wired AND with the slave's enable and holds every level for 40 clocks. It changes SDA only 10 clocks after SCL has fallen, and it places its aborting start and stop conditions only in bytes the master itself is sending.

// File: rtl/i2c_regslave_pkg.sv
package i2c_regslave_pkg;

    // Register bank geometry
    localparam int REG_W     = 8;
    localparam int PTR_W     = 8;
    localparam int REG_COUNT = 1 << PTR_W;

    // Device address: the strap replaces bit 0
    localparam logic [6:0] DEV_ADDR_BASE = 7'h20;

    // Bits per transferred byte (before the acknowledge slot)
    localparam int BYTE_BITS = 8;
    localparam int CNT_W     = $clog2(BYTE_BITS + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_IGNORE
    } slv_state_t;

    // Conditioned bus view after synchronization
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    // Register bank write request
    typedef struct packed {
        logic             we;
        logic [PTR_W-1:0] addr;
        logic [REG_W-1:0] data;
    } reg_wr_t;

    function automatic logic addr_match(input logic [7:0] rx, input logic strap);
        return rx[7:1] == {DEV_ADDR_BASE[6:1], strap};
    endfunction

    function automatic logic is_rx_state(input slv_state_t s);
        return (s == ST_ADDR) || (s == ST_SUB) || (s == ST_WDATA);
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_regslave_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe[0] <= scl_in;
                    sda_pipe[0] <= sda_in;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
                    sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_pipe[LAST];
            sda_prev <= sda_pipe[LAST];
        end
    end

    always_comb begin
        evt.scl      = scl_pipe[LAST];
        evt.sda      = sda_pipe[LAST];
        evt.scl_rise = scl_pipe[LAST] & ~scl_prev;
        evt.scl_fall = ~scl_pipe[LAST] & scl_prev;
        // Data edges while the clock stays high mark the frame boundaries
        evt.start    = scl_pipe[LAST] & scl_prev & sda_prev & ~sda_pipe[LAST];
        evt.stop     = scl_pipe[LAST] & scl_prev & ~sda_prev & sda_pipe[LAST];
    end

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
    import i2c_regslave_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_evt_t         evt,
    input  logic             addr_sel,
    input  logic [REG_W-1:0] rd_data,
    output logic [PTR_W-1:0] ptr,
    output reg_wr_t          wr,
    output logic             sda_oe,
    output slv_state_t       state
);

    localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_BITS);
    localparam logic [CNT_W-1:0] LAST_OUT = CNT_W'(BYTE_BITS - 1);

    logic [CNT_W-1:0] bit_cnt;
    logic [7:0]       shreg;
    logic             rw_bit;
    logic             mst_ack;
    logic             byte_end;

    assign byte_end = evt.scl_fall && (bit_cnt == FULL);

    // Bus write request: a full data byte has ended
    always_comb begin
        wr.we   = (state == ST_WDATA) && byte_end;
        wr.addr = ptr;
        wr.data = shreg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            rw_bit  <= 1'b0;
            mst_ack <= 1'b0;
            sda_oe  <= 1'b0;
            ptr     <= '0;
        end else if (evt.start) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else if (evt.stop) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_SUB, ST_WDATA: begin
                    if (evt.scl_rise && (bit_cnt != FULL)) begin
                        shreg   <= {shreg[6:0], evt.sda};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (byte_end) begin
                        bit_cnt <= '0;
                        if (state == ST_ADDR) begin
                            if (addr_match(shreg, addr_sel)) begin
                                rw_bit <= shreg[0];
                                sda_oe <= 1'b1;
                                state  <= ST_ADDR_ACK;
                            end else begin
                                state  <= ST_IGNORE;
                            end
                        end else if (state == ST_SUB) begin
                            ptr    <= shreg;
                            sda_oe <= 1'b1;
                            state  <= ST_SUB_ACK;
                        end else begin
                            ptr    <= ptr + 1'b1;
                            sda_oe <= 1'b1;
                            state  <= ST_WDATA_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (evt.scl_fall) begin
                        if (rw_bit) begin
                            shreg  <= rd_data;
                            sda_oe <= ~rd_data[7];
                            state  <= ST_RDATA;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_SUB;
                        end
                    end
                end
                ST_SUB_ACK, ST_WDATA_ACK: begin
                    if (evt.scl_fall) begin
                        sda_oe <= 1'b0;
                        state  <= ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (evt.scl_fall) begin
                        if (bit_cnt == LAST_OUT) begin
                            bit_cnt <= '0;
                            sda_oe  <= 1'b0;
                            ptr     <= ptr + 1'b1;
                            state   <= ST_RDATA_ACK;
                        end else begin
                            shreg   <= {shreg[6:0], 1'b0};
                            sda_oe  <= ~shreg[6];
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_RDATA_ACK: begin
                    if (evt.scl_rise) begin
                        mst_ack <= ~evt.sda;
                    end else if (evt.scl_fall) begin
                        if (mst_ack) begin
                            shreg  <= rd_data;
                            sda_oe <= ~rd_data[7];
                            state  <= ST_RDATA;
                        end else begin
                            state  <= ST_IGNORE;
                        end
                    end
                end
                default: begin
                    // ST_IDLE, ST_IGNORE: wait for the next start
                end
            endcase
        end
    end

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
    import i2c_regslave_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  reg_wr_t          bus_wr,
    input  logic [PTR_W-1:0] bus_raddr,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             tst_we,
    input  logic [PTR_W-1:0] tst_addr,
    input  logic [REG_W-1:0] tst_wdata,
    output logic [REG_W-1:0] tst_rdata
);

    logic [REG_W-1:0] mem [REG_COUNT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REG_COUNT; i++) begin
                mem[i] <= '0;
            end
        end else if (bus_wr.we) begin
            mem[bus_wr.addr] <= bus_wr.data;
        end else if (tst_we) begin
            mem[tst_addr] <= tst_wdata;
        end
    end

    assign bus_rdata = mem[bus_raddr];
    assign tst_rdata = mem[tst_addr];

endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave
    import i2c_regslave_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe,
    input  logic       addr_sel,
    input  logic       tst_we,
    input  logic [7:0] tst_addr,
    input  logic [7:0] tst_wdata,
    output logic [7:0] tst_rdata
);

    bus_evt_t         evt;
    reg_wr_t          bus_wr;
    slv_state_t       state;
    logic [PTR_W-1:0] ptr;
    logic [REG_W-1:0] rd_data;
    logic             scl_s;

    assign scl_s = evt.scl;

    i2c_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    i2c_slave_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .addr_sel (addr_sel),
        .rd_data  (rd_data),
        .ptr      (ptr),
        .wr       (bus_wr),
        .sda_oe   (sda_oe),
        .state    (state)
    );

    i2c_reg_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_raddr (ptr),
        .bus_rdata (rd_data),
        .tst_we    (tst_we),
        .tst_addr  (tst_addr),
        .tst_wdata (tst_wdata),
        .tst_rdata (tst_rdata)
    );

endmodule

// File: rtl/i2c_regslave_chk.sv
module i2c_regslave_chk
    import i2c_regslave_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             sda_oe,
    input logic             scl_s,
    input slv_state_t       state,
    input logic             bus_we,
    input logic [PTR_W-1:0] ptr
);

    // R3, R7: no pull-down while waiting for a start
    assert_quiet_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_IDLE) || (state == ST_IGNORE)) |-> !sda_oe);

    // R4: the slave never pulls SDA while the master is sending bits
    assert_no_drive_on_rx_R4: assert property (@(posedge clk) disable iff (rst)
        is_rx_state(state) |-> !sda_oe);

    // R6: the output only moves after SCL has been seen low
    assert_oe_moves_on_scl_low_R6: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

    // R5: every stored byte advances the pointer by one
    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (rst)
        bus_we |=> (ptr == $past(ptr) + 1'b1));

endmodule

bind i2c_regslave i2c_regslave_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .sda_oe (sda_oe),
    .scl_s  (scl_s),
    .state  (state),
    .bus_we (bus_wr.we),
    .ptr    (ptr)
);

// File: tb/i2c_regslave_test.sv
`timescale 1ns/1ps
module i2c_regslave_test;

    localparam int Q  = 40;   // clocks per SCL level
    localparam int GAP = 10;  // clocks between SCL fall and SDA change

    logic       clk = 1'b0;
    logic       rst;
    logic       scl_m;
    logic       sda_m;
    logic       addr_sel;
    logic       tst_we;
    logic [7:0] tst_addr;
    logic [7:0] tst_wdata;
    logic [7:0] tst_rdata;
    logic       sda_oe;
    logic       sda_line;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_regslave uut (
        .clk       (clk),
        .rst       (rst),
        .scl_in    (scl_m),
        .sda_in    (sda_line),
        .sda_oe    (sda_oe),
        .addr_sel  (addr_sel),
        .tst_we    (tst_we),
        .tst_addr  (tst_addr),
        .tst_wdata (tst_wdata),
        .tst_rdata (tst_rdata)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(GAP);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(Q);
            scl_m = 1'b0; tick(GAP);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q / 2);
        ack = sda_oe;
        tick(Q / 2);
        scl_m = 1'b0; tick(GAP);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b, output logic rel);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_m = 1'b1; tick(Q / 2);
            b[i] = sda_line;
            tick(Q / 2);
            scl_m = 1'b0; tick(GAP);
        end
        sda_m = ~give_ack; tick(Q);
        scl_m = 1'b1; tick(Q / 2);
        rel = ~sda_oe;
        tick(Q / 2);
        scl_m = 1'b0; tick(GAP);
        sda_m = 1'b1;
    endtask

    task automatic tst_write(input logic [7:0] a, input logic [7:0] d);
        tst_addr = a; tst_wdata = d; tst_we = 1'b1;
        tick(1);
        tst_we = 1'b0;
        tick(1);
    endtask

    task automatic tst_read(input logic [7:0] a, output logic [7:0] d);
        tst_addr = a;
        tick(1);
        d = tst_rdata;
    endtask

    task automatic test_reset();
        logic [7:0] d;
        chk("R1 sda_oe after reset", {7'd0, sda_oe}, 8'h00);
        tst_read(8'h00, d);
        chk("R1 reg 00 after reset", d, 8'h00);
        tst_read(8'hFF, d);
        chk("R1 reg FF after reset", d, 8'h00);
    endtask

    task automatic test_write_burst();
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte(8'h40, a); chk("R2 ack 0x40 strap 0", {7'd0, a}, 8'h01);
        send_byte(8'h10, a); chk("R4 ack pointer byte", {7'd0, a}, 8'h01);
        send_byte(8'h11, a); chk("R4 ack data 1", {7'd0, a}, 8'h01);
        send_byte(8'h22, a); chk("R4 ack data 2", {7'd0, a}, 8'h01);
        send_byte(8'h33, a); chk("R4 ack data 3", {7'd0, a}, 8'h01);
        bus_stop();
        tst_read(8'h10, d); chk("R4 reg 10", d, 8'h11);
        tst_read(8'h11, d); chk("R5 reg 11", d, 8'h22);
        tst_read(8'h12, d); chk("R5 reg 12", d, 8'h33);
    endtask

    task automatic test_wrap();
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte(8'h40, a);
        send_byte(8'hFE, a);
        send_byte(8'hA1, a);
        send_byte(8'hB2, a);
        send_byte(8'hC3, a);
        bus_stop();
        tst_read(8'hFE, d); chk("R5 reg FE", d, 8'hA1);
        tst_read(8'hFF, d); chk("R5 reg FF", d, 8'hB2);
        tst_read(8'h00, d); chk("R5 wrap to reg 00", d, 8'hC3);
    endtask

    task automatic test_read_continue();
        logic a, rel;
        logic [7:0] d;
        tst_write(8'h01, 8'h5C);
        tst_write(8'h02, 8'h6D);
        tst_read(8'h01, d); chk("R10 test port write", d, 8'h5C);
        bus_start();
        send_byte(8'h41, a); chk("R2 ack 0x41 strap 0", {7'd0, a}, 8'h01);
        recv_byte(1'b1, d, rel);
        chk("R11 read continues at pointer 01", d, 8'h5C);
        chk("R6 released in ack slot", {7'd0, rel}, 8'h01);
        recv_byte(1'b0, d, rel);
        chk("R6 second read byte", d, 8'h6D);
        bus_stop();
    endtask

    task automatic test_ptr_then_read();
        logic a, rel;
        logic [7:0] d;
        int drove;
        tst_write(8'h40, 8'h9E);
        tst_write(8'h41, 8'h4B);
        tst_write(8'h42, 8'h77);
        bus_start();
        send_byte(8'h40, a);
        send_byte(8'h40, a); chk("R8 pointer byte ack", {7'd0, a}, 8'h01);
        bus_start();
        send_byte(8'h41, a); chk("R8 repeated start read ack", {7'd0, a}, 8'h01);
        recv_byte(1'b1, d, rel); chk("R8 read at written pointer", d, 8'h9E);
        recv_byte(1'b0, d, rel); chk("R8 next register", d, 8'h4B);
        // R7: after the not-acknowledge the slave keeps SDA released
        drove = 0;
        sda_m = 1'b1;
        for (int i = 0; i < 4 * Q; i++) begin
            if (i % Q == 0) scl_m = ~scl_m;
            tick(1);
            if (sda_oe) drove++;
        end
        scl_m = 1'b0; tick(GAP);
        chk("R7 no drive after nack", 8'(drove), 8'h00);
        bus_stop();
        bus_start();
        send_byte(8'h41, a);
        recv_byte(1'b0, d, rel);
        chk("R5 pointer advanced after read", d, 8'h77);
        bus_stop();
    endtask

    task automatic test_strap();
        logic a;
        logic [7:0] d;
        addr_sel = 1'b1;
        tick(4);
        bus_start();
        send_byte(8'h40, a); chk("R2 0x40 refused with strap 1", {7'd0, a}, 8'h00);
        bus_stop();
        bus_start();
        send_byte(8'h42, a); chk("R2 ack 0x42 strap 1", {7'd0, a}, 8'h01);
        send_byte(8'h20, a);
        send_byte(8'hEE, a);
        bus_stop();
        tst_read(8'h20, d); chk("R2 write via 0x42", d, 8'hEE);
        addr_sel = 1'b0;
        tick(4);
    endtask

    task automatic test_mismatch();
        logic a1, a2, a3;
        logic [7:0] d;
        tst_write(8'h50, 8'hA5);
        bus_start();
        send_byte(8'h44, a1);
        send_byte(8'h50, a2);
        send_byte(8'h12, a3);
        bus_stop();
        chk("R3 no ack for 0x44", {7'd0, a1}, 8'h00);
        chk("R3 no ack after mismatch", {6'd0, a2, a3}, 8'h00);
        tst_read(8'h50, d); chk("R3 reg 50 untouched", d, 8'hA5);
    endtask

    task automatic test_abort();
        logic a;
        logic [7:0] d;
        tst_write(8'h60, 8'h3C);
        bus_start();
        send_byte(8'h40, a);
        send_byte(8'h60, a);
        send_bits(8'hFF, 4);
        bus_stop();
        tst_read(8'h60, d); chk("R9 stop mid byte writes nothing", d, 8'h3C);
        bus_start();
        send_byte(8'h40, a);
        send_byte(8'h61, a);
        send_bits(8'hE7, 3);
        bus_start();
        send_byte(8'h40, a); chk("R9 address after mid-byte start", {7'd0, a}, 8'h01);
        send_byte(8'h62, a);
        send_byte(8'h81, a);
        bus_stop();
        tst_read(8'h61, d); chk("R9 aborted byte not stored", d, 8'h00);
        tst_read(8'h62, d); chk("R9 write after restart", d, 8'h81);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        rst = 1'b1; scl_m = 1'b1; sda_m = 1'b1; addr_sel = 1'b0;
        tst_we = 1'b0; tst_addr = '0; tst_wdata = '0;
        tick(5);
        rst = 1'b0;
        tick(5);
        test_reset();
        test_write_burst();
        test_wrap();
        test_read_continue();
        test_ptr_then_read();
        test_strap();
        test_mismatch();
        test_abort();
        tick(20);
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

endmodule